// File: doc/BRIEF.md
# Tagged Bias-Exception Branch Direction Predictor

This block predicts the direction of conditional branches. A table of 2-bit counters, indexed by low bits of the branch address, gives a base direction. Most branches follow a steady bias, so that base is usually right. Two small tagged caches record the cases where a branch goes against its base direction. One cache holds instances that resolve taken. The other holds instances that resolve not-taken. The base direction decides which cache is consulted. That cache is indexed by the branch address XORed with the global outcome history. When the partial tag matches, the cached counter overrides the base direction.

The fetch side presents a branch address on the predict port and receives a direction in the same cycle. The predict port uses the internal history register. When a branch resolves, the back end presents its address, its outcome and the history value that was used at predict time. The block then trains the tables and shifts the outcome into the history register. The current history is exported so that the front end can keep it with each branch.

Top module: `tagged_bias_predictor`

## Requirements
- R1: While reset is held and after it is released, every base counter reads 01 (weakly not-taken), every cache entry is invalid and the history register is zero. A prediction at any address is therefore not-taken.
- R2: The base direction is the most significant bit of the base counter selected by the low BIM_IDX_W address bits. On a cache miss, the predicted direction equals this base direction.
- R3: Every 2-bit counter steps up by one on a taken outcome and down by one on a not-taken outcome, and stays put at 3 and at 0.
- R4: A base direction of 1 (taken) consults the not-taken cache. A base direction of 0 consults the taken cache. Both caches are indexed by address bits [EXC_IDX_W-1:0] XOR history.
- R5: An entry hits when it is valid and its stored tag equals address bits [TAG_W-1:0]. On a hit, the prediction is the most significant bit of that entry's counter.
- R6: On an update that misses in the selected cache and whose outcome differs from the base direction, the selected entry is written valid, with the branch's tag and a counter of 10 for taken or 01 for not-taken.
- R7: On an update that hits, the hitting entry's counter is trained. The base counter is trained on every update except one that hits, predicts correctly and resolves against the base direction.
- R8: Each update shifts the resolved outcome into bit 0 of the history register and moves the older bits up by one place. Without an update, the history holds. `ghr_out` shows the register.
- R9: An update indexes the caches with `upd_hist`, not with the current history register.
- R10: A prediction is combinational on registered state. When a predict and an update hit the same entries in one cycle, the prediction reflects the state before that update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; its release is synchronized inside |
| pred_pc | input | PC_W | Address of the branch being predicted |
| pred_taken | output | 1 | Predicted direction, 1 = taken |
| upd_valid | input | 1 | A resolved branch is presented this cycle |
| upd_pc | input | PC_W | Address of the resolved branch |
| upd_taken | input | 1 | Resolved outcome, 1 = taken |
| upd_hist | input | EXC_IDX_W | History value that was used when this branch was predicted |
| ghr_out | output | EXC_IDX_W | Current global history register |

## Verification
The hardest case to reach from the ports is a hit in an exception cache whose entry was written under a history value that differs from the register's current value. Getting there needs a biased base counter, an allocation, and then a return to the same index through the internal history. The bench uses a tiny configuration of 8 base counters and 4-entry caches. It drives thousands of address and outcome patterns that depend on the address and on the history, and it replaces `upd_hist` with an unrelated value for about a quarter of the updates. Between these runs it sweeps every address at each history value. An arithmetic model of the tables then predicts each output.

// File: rtl/tbp_pkg.sv
package tbp_pkg;

  typedef logic [1:0] ctr2_t;

  localparam ctr2_t CTR_WEAK_NT = 2'b01;
  localparam ctr2_t CTR_WEAK_T  = 2'b10;

  // Saturating 2-bit step: up on taken, down on not-taken
  function automatic ctr2_t ctr_step(ctr2_t c, logic up);
    if (up) return (c == 2'b11) ? c : c + 2'd1;
    else    return (c == 2'b00) ? c : c - 2'd1;
  endfunction

endpackage

// File: rtl/tbp_bias_table.sv
module tbp_bias_table
  import tbp_pkg::*;
#(
  parameter int IDX_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_idx_a,
  output ctr2_t            rd_ctr_a,
  input  logic [IDX_W-1:0] rd_idx_b,
  output ctr2_t            rd_ctr_b,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_taken
);
  localparam int DEPTH = 1 << IDX_W;

  ctr2_t tbl_q [DEPTH];
  ctr2_t wr_val;

  assign rd_ctr_a = tbl_q[rd_idx_a];
  assign rd_ctr_b = tbl_q[rd_idx_b];

  always_comb begin
    wr_val = ctr_step(tbl_q[wr_idx], wr_taken);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) tbl_q[i] <= CTR_WEAK_NT;
    end else if (wr_en) begin
      tbl_q[wr_idx] <= wr_val;
    end
  end

  // R3: saturation at both ends
  a_r3_sat_top: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_taken && tbl_q[wr_idx] == 2'b11) |=> tbl_q[$past(wr_idx)] == 2'b11);
  a_r3_sat_bottom: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_taken && tbl_q[wr_idx] == 2'b00) |=> tbl_q[$past(wr_idx)] == 2'b00);

endmodule

// File: rtl/tbp_exc_cache.sv
module tbp_exc_cache
  import tbp_pkg::*;
#(
  parameter int IDX_W = 8,
  parameter int TAG_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] lk_idx_a,
  input  logic [TAG_W-1:0] lk_tag_a,
  output logic             hit_a,
  output ctr2_t            ctr_a,
  input  logic [IDX_W-1:0] lk_idx_b,
  input  logic [TAG_W-1:0] lk_tag_b,
  output logic             hit_b,
  output ctr2_t            ctr_b,
  input  logic             trn_en,
  input  logic             alloc_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [TAG_W-1:0] wr_tag,
  input  logic             wr_taken
);
  localparam int DEPTH = 1 << IDX_W;

  typedef struct packed {
    logic             vld;
    logic [TAG_W-1:0] tag;
    ctr2_t            ctr;
  } ent_t;

  ent_t ent_q [DEPTH];
  ent_t wr_ent;
  logic wr_en;

  assign hit_a = ent_q[lk_idx_a].vld && (ent_q[lk_idx_a].tag == lk_tag_a);
  assign ctr_a = ent_q[lk_idx_a].ctr;
  assign hit_b = ent_q[lk_idx_b].vld && (ent_q[lk_idx_b].tag == lk_tag_b);
  assign ctr_b = ent_q[lk_idx_b].ctr;

  assign wr_en = alloc_en | trn_en;

  always_comb begin
    wr_ent = ent_q[wr_idx];
    if (alloc_en) begin
      wr_ent.vld = 1'b1;
      wr_ent.tag = wr_tag;
      wr_ent.ctr = wr_taken ? CTR_WEAK_T : CTR_WEAK_NT;
    end else begin
      wr_ent.ctr = ctr_step(ent_q[wr_idx].ctr, wr_taken);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) ent_q[i] <= '{vld: 1'b0, tag: '0, ctr: CTR_WEAK_NT};
    end else if (wr_en) begin
      ent_q[wr_idx] <= wr_ent;
    end
  end

  // R6: an allocation leaves a valid entry holding the written tag
  a_r6_alloc_fills: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_en |=> (ent_q[$past(wr_idx)].vld && ent_q[$past(wr_idx)].tag == $past(wr_tag)));
  // R7: training and allocation never target a cache together
  a_r7_train_xor_alloc: assert property (@(posedge clk) disable iff (!rst_n)
    !(alloc_en && trn_en));

endmodule

// File: rtl/tbp_history.sv
module tbp_history #(
  parameter int HIST_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              shift_en,
  input  logic              bit_in,
  output logic [HIST_W-1:0] hist
);
  logic [HIST_W-1:0] hist_q, hist_d;

  always_comb begin
    hist_d = {hist_q[HIST_W-2:0], bit_in};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        hist_q <= '0;
    else if (shift_en) hist_q <= hist_d;
  end

  assign hist = hist_q;

  // R8: shift-in and hold
  a_r8_shift_in: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en |=> (hist_q[0] == $past(bit_in)) && (hist_q[HIST_W-1:1] == $past(hist_q[HIST_W-2:0])));
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_en |=> $stable(hist_q));

endmodule

// File: rtl/tagged_bias_predictor.sv
module tagged_bias_predictor
  import tbp_pkg::*;
#(
  parameter int PC_W      = 32,
  parameter int BIM_IDX_W = 10,
  parameter int EXC_IDX_W = 8,
  parameter int TAG_W     = 6
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [PC_W-1:0]      pred_pc,
  output logic                 pred_taken,
  input  logic                 upd_valid,
  input  logic [PC_W-1:0]      upd_pc,
  input  logic                 upd_taken,
  input  logic [EXC_IDX_W-1:0] upd_hist,
  output logic [EXC_IDX_W-1:0] ghr_out
);
  localparam int HIST_W = EXC_IDX_W;
  localparam int N_CACHE = 2;  // index 1 holds taken exceptions, 0 not-taken

  // reset: asserts at once, releases on the clock
  logic rst_meta_q, rst_sync_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  logic unused_pc_bits;
  assign unused_pc_bits = ^{pred_pc, upd_pc};

  logic [HIST_W-1:0] ghr;

  // predict side
  logic [BIM_IDX_W-1:0] p_bidx;
  logic [EXC_IDX_W-1:0] p_eidx;
  logic [TAG_W-1:0]     p_tag;
  ctr2_t                p_base_ctr;
  logic                 p_base, p_sel;
  logic                 p_hit  [N_CACHE];
  ctr2_t                p_ctr  [N_CACHE];

  // update side
  logic [BIM_IDX_W-1:0] u_bidx;
  logic [EXC_IDX_W-1:0] u_eidx;
  logic [TAG_W-1:0]     u_tag;
  ctr2_t                u_base_ctr;
  logic                 u_base, u_sel, u_hit, u_final, u_bim_wr;
  logic                 u_hit_c  [N_CACHE];
  ctr2_t                u_ctr_c  [N_CACHE];
  logic                 alloc_en [N_CACHE];
  logic                 trn_en   [N_CACHE];

  always_comb begin
    p_bidx = pred_pc[BIM_IDX_W-1:0];
    p_eidx = pred_pc[EXC_IDX_W-1:0] ^ ghr;
    p_tag  = pred_pc[TAG_W-1:0];
    p_base = p_base_ctr[1];
    p_sel  = ~p_base;
    pred_taken = p_hit[p_sel] ? p_ctr[p_sel][1] : p_base;
  end

  always_comb begin
    u_bidx  = upd_pc[BIM_IDX_W-1:0];
    u_eidx  = upd_pc[EXC_IDX_W-1:0] ^ upd_hist;
    u_tag   = upd_pc[TAG_W-1:0];
    u_base  = u_base_ctr[1];
    u_sel   = ~u_base;
    u_hit   = u_hit_c[u_sel];
    u_final = u_hit ? u_ctr_c[u_sel][1] : u_base;
    u_bim_wr = upd_valid && !(u_hit && (u_final == upd_taken) && (upd_taken != u_base));
  end

  tbp_bias_table #(.IDX_W(BIM_IDX_W)) u_bias (
    .clk      (clk),
    .rst_n    (rst_sync_q),
    .rd_idx_a (p_bidx),
    .rd_ctr_a (p_base_ctr),
    .rd_idx_b (u_bidx),
    .rd_ctr_b (u_base_ctr),
    .wr_en    (u_bim_wr),
    .wr_idx   (u_bidx),
    .wr_taken (upd_taken)
  );

  for (genvar g = 0; g < N_CACHE; g++) begin : g_cache
    always_comb begin
      trn_en[g]   = upd_valid && u_hit && (u_sel == 1'(g));
      alloc_en[g] = upd_valid && !u_hit && (upd_taken != u_base) && (u_sel == 1'(g));
    end

    tbp_exc_cache #(.IDX_W(EXC_IDX_W), .TAG_W(TAG_W)) u_exc (
      .clk      (clk),
      .rst_n    (rst_sync_q),
      .lk_idx_a (p_eidx),
      .lk_tag_a (p_tag),
      .hit_a    (p_hit[g]),
      .ctr_a    (p_ctr[g]),
      .lk_idx_b (u_eidx),
      .lk_tag_b (u_tag),
      .hit_b    (u_hit_c[g]),
      .ctr_b    (u_ctr_c[g]),
      .trn_en   (trn_en[g]),
      .alloc_en (alloc_en[g]),
      .wr_idx   (u_eidx),
      .wr_tag   (u_tag),
      .wr_taken (upd_taken)
    );
  end

  tbp_history #(.HIST_W(HIST_W)) u_hist (
    .clk      (clk),
    .rst_n    (rst_sync_q),
    .shift_en (upd_valid),
    .bit_in   (upd_taken),
    .hist     (ghr)
  );

  assign ghr_out = ghr;

  // R6: allocation only into the cache matching the outcome, on a miss
  a_r6_alloc_direction: assert property (@(posedge clk) disable iff (!rst_sync_q)
    alloc_en[1] |-> (upd_taken && !u_base_ctr[1] && !u_hit_c[1]));
  a_r6_alloc_direction_nt: assert property (@(posedge clk) disable iff (!rst_sync_q)
    alloc_en[0] |-> (!upd_taken && u_base_ctr[1] && !u_hit_c[0]));
  // R4: at most one cache is written per update
  a_r4_one_cache: assert property (@(posedge clk) disable iff (!rst_sync_q)
    $countones({alloc_en[0] | trn_en[0], alloc_en[1] | trn_en[1]}) <= 1);
  // R1: nothing is predicted taken straight after reset
  a_r1_reset_nt: assert property (@(posedge clk)
    !rst_sync_q |=> (rst_sync_q ? 1'b1 : !pred_taken));

endmodule

// File: tb/tagged_bias_predictor_test.sv
module tagged_bias_predictor_test;
  localparam int PW = 6, BW = 3, EW = 2, TW = 2;
  localparam int NB = 1 << BW, NE = 1 << EW;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic          rst_n;
  logic [PW-1:0] pred_pc, upd_pc;
  logic          pred_taken, upd_valid, upd_taken;
  logic [EW-1:0] upd_hist, ghr_out;

  tagged_bias_predictor #(.PC_W(PW), .BIM_IDX_W(BW), .EXC_IDX_W(EW), .TAG_W(TW)) uut (
    .clk(clk), .rst_n(rst_n), .pred_pc(pred_pc), .pred_taken(pred_taken),
    .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_taken(upd_taken),
    .upd_hist(upd_hist), .ghr_out(ghr_out)
  );

  int checks = 0, errors = 0;
  bit finished = 0;

  // arithmetic model
  logic [1:0]    m_bim [NB];
  logic          m_vld [2][NE];
  logic [TW-1:0] m_tag [2][NE];
  logic [1:0]    m_ct  [2][NE];
  bit            m_byalloc [2][NE];
  bit            m_alt [2][NE];
  logic [EW-1:0] m_ghr;
  logic [15:0]   lfsr = 16'hACE1;

  function automatic logic [1:0] step(logic [1:0] c, logic up);
    if (up) return (c == 3) ? c : c + 2'd1;
    return (c == 0) ? c : c - 2'd1;
  endfunction

  task automatic rnd();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  task automatic chk(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0b expected=%0b pc=%0d ghr=%0d", req, act, exp, pred_pc, m_ghr);
    end
  endtask

  // expected prediction for an address under the model's history
  task automatic model_predict(input logic [PW-1:0] pc, output logic exp, output string req);
    int b, s, e;
    logic base;
    b = int'(pc) % NB;
    base = m_bim[b][1];
    s = base ? 0 : 1;
    e = (int'(pc) % NE) ^ int'(m_ghr);
    if (m_vld[s][e] && m_tag[s][e] == pc[TW-1:0]) begin
      exp = m_ct[s][e][1];
      req = $sformatf("R4/R5/%s%s", m_byalloc[s][e] ? "R6" : "R7", m_alt[s][e] ? "/R9" : "");
    end else begin
      exp = base;
      req = (m_bim[b] == 0 || m_bim[b] == 3) ? "R2/R3" : "R2";
    end
  endtask

  task automatic model_update(logic [PW-1:0] pc, logic tk, logic [EW-1:0] h);
    int b, s, e;
    logic base, hit, fin;
    b = int'(pc) % NB;
    base = m_bim[b][1];
    s = base ? 0 : 1;
    e = (int'(pc) % NE) ^ int'(h);
    hit = m_vld[s][e] && m_tag[s][e] == pc[TW-1:0];
    fin = hit ? m_ct[s][e][1] : base;
    if (hit) begin
      m_ct[s][e] = step(m_ct[s][e], tk);
      m_byalloc[s][e] = 0;
      m_alt[s][e] = m_alt[s][e] | (h != m_ghr);
    end else if (tk != base) begin
      m_vld[s][e] = 1; m_tag[s][e] = pc[TW-1:0];
      m_ct[s][e] = tk ? 2'b10 : 2'b01;
      m_byalloc[s][e] = 1;
      m_alt[s][e] = (h != m_ghr);
    end
    if (!(hit && fin == tk && tk != base)) m_bim[b] = step(m_bim[b], tk);
    m_ghr = {m_ghr[EW-2:0], tk};
  endtask

  // one cycle: drive at negedge, check before posedge, model after posedge
  task automatic cycle(logic [PW-1:0] ppc, logic uv, logic [PW-1:0] upc, logic utk, logic [EW-1:0] uh);
    logic exp;
    string req;
    @(negedge clk);
    pred_pc = ppc; upd_valid = uv; upd_pc = upc; upd_taken = utk; upd_hist = uh;
    #1;
    model_predict(ppc, exp, req);
    if (uv && ppc == upc) req = {req, "/R10"};
    chk(req, pred_taken, exp);
    checks++;
    if (ghr_out !== m_ghr) begin
      errors++;
      $display("FAIL R8 ghr actual=%0d expected=%0d", ghr_out, m_ghr);
    end
    @(posedge clk);
    if (uv) model_update(upc, utk, uh);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    summary();
  end

  initial begin
    rst_n = 0; pred_pc = 0; upd_valid = 0; upd_pc = 0; upd_taken = 0; upd_hist = 0;
    for (int i = 0; i < NB; i++) m_bim[i] = 2'b01;
    for (int s = 0; s < 2; s++)
      for (int e = 0; e < NE; e++) begin
        m_vld[s][e] = 0; m_tag[s][e] = 0; m_ct[s][e] = 2'b01;
        m_byalloc[s][e] = 0; m_alt[s][e] = 0;
      end
    m_ghr = 0;
    repeat (3) @(negedge clk);
    // R1: during reset, nothing predicted taken
    for (int p = 0; p < (1 << PW); p++) begin
      pred_pc = p[PW-1:0];
      #0.1;
      chk("R1", pred_taken, 1'b0);
    end
    rst_n = 1;
    repeat (4) @(negedge clk);
    // R1: after release, all addresses not-taken, history zero
    for (int p = 0; p < (1 << PW); p++) cycle(p[PW-1:0], 0, 0, 0, 0);
    chk("R1", (ghr_out == 0), 1'b1);

    // R3: drive one address taken repeatedly into saturation, then back down
    for (int k = 0; k < 6; k++) cycle(6'd3, 1, 6'd3, 1, m_ghr);
    for (int k = 0; k < 6; k++) cycle(6'd3, 1, 6'd3, 0, m_ghr);

    // main patterned runs with sweeps in between
    for (int round = 0; round < 8; round++) begin
      for (int k = 0; k < 600; k++) begin
        logic [PW-1:0] upc, ppc;
        logic tk;
        logic [EW-1:0] h;
        rnd();
        upc = lfsr[PW-1:0];
        ppc = lfsr[3] ? upc : lfsr[PW+5:6];
        tk = upc[0] ^ (m_ghr == {EW{1'b1}}) ^ upc[round % PW];
        if (lfsr[15:13] == 3'b000) tk = ~tk;
        h = (lfsr[12:11] == 2'b00) ? lfsr[10:9] : m_ghr;
        cycle(ppc, lfsr[8] | lfsr[7], upc, tk, h);
      end
      // sweep every address under every history value
      for (int hv = 0; hv < NE; hv++) begin
        cycle(0, 1, 6'd63, hv[1], m_ghr);
        cycle(0, 1, 6'd63, hv[0], m_ghr);
        for (int p = 0; p < (1 << PW); p++) cycle(p[PW-1:0], 0, 0, 0, 0);
      end
    end
    summary();
  end

endmodule